// File: doc/BRIEF.md
# Receive Chunk Footer Deframer

This block sits on the host side of a chunked serial link. Receive data arrives one byte at a time in fixed chunks. Each chunk is 64 payload bytes followed by a 32-bit trailer that is sent most significant byte first. Whether the payload holds frame data, and where frames begin and end in it, is known only once that trailer is complete. The block therefore writes each payload into one of two banks. When the trailer is in, it checks the trailer's parity and decodes it. It then replays the chosen bytes of the stored bank as a byte stream, with start-of-frame, end-of-frame, drop and timestamp-present flags. While one bank is being replayed, the next chunk fills the other bank.

The same trailer also carries link status: the number of further receive chunks that are ready, the transmit credits, and three status flags. The block captures these from every trailer whose parity is good and holds them on outputs for other logic. A trailer with bad parity, and an end marker that arrives with no frame open, each raise a one-cycle error pulse.

Intake runs a two-state machine. COLLECT_PAYLOAD (C_PAYLOAD) stores bytes 0..63. On byte 63 it moves to COLLECT_TRAILER (C_FOOTER). On the last trailer byte it posts the trailer, swaps banks and returns to C_PAYLOAD. The replay machine has three states. EM_IDLE waits for a posted trailer. From EM_IDLE it moves to EM_TAIL when the chunk continues or closes an open frame, to EM_HEAD when it only starts a frame, and otherwise stays in EM_IDLE. EM_TAIL moves to EM_HEAD at its last byte if a new frame follows, and otherwise to EM_IDLE. EM_HEAD returns to EM_IDLE after its last byte.

Top module: `rxchunk_deframer`

## Requirements
- R1: Chunk framing counts accepted bytes (rx_vld high) from reset, with no gaps between chunks. Bytes 0..63 of a chunk are payload. Bytes 64..67 form the trailer, most significant byte first. Idle cycles between accepted bytes are allowed anywhere.
- R2: A trailer is accepted only if the XOR of all its 32 bits is 1 (odd parity, checked with bit 0 included). If the parity fails, par_err pulses for one cycle, two clock edges after the last trailer byte is accepted. No byte of that chunk is emitted, the status outputs keep their values, and an open frame stays open.
- R3: With bit 21 (data valid) clear, no payload byte is emitted. The status outputs are still updated.
- R4: Bit 20 (start valid) marks a new frame starting at byte 4*N, where N is bits 19..16. The first byte of the frame is emitted with out_sof set, and out_ts equal to trailer bit 7.
- R5: Bit 14 (end valid) marks byte B as the last byte of a frame, where B is bits 13..8. That byte is emitted with out_eof set, and out_drop equal to trailer bit 15. out_drop is never set on any other byte.
- R6: When both the start and end marks are set and B < 4*N, bytes 0..B are emitted first to close the open frame. Bytes 4*N..63 are then emitted as a new frame, which stays open.
- R7: An end mark with no frame open makes proto_err pulse in the same cycle where par_err would. The closing bytes are not emitted.
- R8: When data is valid, no mark is set and a frame is open, all 64 bytes are emitted as a continuation. With no frame open, nothing is emitted.
- R9: When both marks are set and B >= 4*N, bytes 4*N..B are emitted as one complete frame. A start mark while a frame is open abandons the old frame without an end-of-frame byte.
- R10: Each good trailer loads the following outputs: st_rca from bits 28..24, st_txc from bits 5..1, st_exst from bit 31, st_hdrb from bit 30 and st_sync from bit 29. They change two clock edges after the last trailer byte. After reset all of them read 0.
- R11: Bytes may be accepted on every cycle with no loss. Replay of one chunk always ends before the next trailer completes. Bytes come out one per cycle, in payload order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_vld | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_drop | output | 1 | Frame ending here should be discarded |
| out_ts | output | 1 | Frame starting here carries a timestamp prefix |
| par_err | output | 1 | Trailer parity error pulse |
| proto_err | output | 1 | End mark without open frame pulse |
| st_rca | output | 5 | Further receive chunks ready |
| st_txc | output | 5 | Transmit credits |
| st_exst | output | 1 | Extended status flag |
| st_hdrb | output | 1 | Bad header seen by the far side |
| st_sync | output | 1 | Configuration synchronized flag |

## Verification
A byte counter that slips out of step with the chunk boundary shows up within one chunk. The trailer bits then come from payload bytes, so parity errors and misplaced bytes appear two edges after the supposed last trailer byte. A wrong frame-open bit shows up at the next chunk as a false proto_err, a missing continuation, or an end-of-frame that should not be there. A replay position or bank that is off by one changes the byte values or the flag positions in the first emitted byte of the chunk.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

    // Trailer layout; field positions are fixed by the link format.
    typedef struct packed {
        logic       exst;
        logic       hdrb;
        logic       sync;
        logic [4:0] rca;
        logic [1:0] vs;
        logic       dv;
        logic       sv;
        logic [3:0] swo;
        logic       fd;
        logic       ev;
        logic [5:0] ebo;
        logic       rtsa;
        logic       rtsp;
        logic [4:0] txc;
        logic       par;
    } trailer_t;

    typedef enum logic {C_PAYLOAD, C_FOOTER} col_st_t;

    typedef enum logic [1:0] {EM_IDLE, EM_TAIL, EM_HEAD} em_st_t;

    function automatic logic trailer_good(input trailer_t t);
        return ^t;
    endfunction

endpackage

// File: rtl/rdf_collect.sv
module rdf_collect
    import rdf_pkg::*;
#(
    parameter int PAY   = 64,
    parameter int TRL   = 4,
    parameter int BANKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_vld,
    input  logic [7:0]                 rx_byte,
    input  logic [$clog2(BANKS)-1:0]   rd_bank,
    input  logic [$clog2(PAY)-1:0]     rd_pos,
    output logic [7:0]                 rd_byte,
    output logic                       go,
    output trailer_t                   go_trl,
    output logic [$clog2(BANKS)-1:0]   go_bank
);
    localparam int CHUNK = PAY + TRL;
    localparam int CW    = $clog2(CHUNK);
    localparam int PW    = $clog2(PAY);
    localparam int BW    = $clog2(BANKS);

    col_st_t        st, st_nx;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  wbank;
    logic [23:0]    shreg;
    logic [7:0]     rd_lane [BANKS];

    wire last_pay = (cnt == CW'(PAY - 1));
    wire last_trl = (cnt == CW'(CHUNK - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            C_PAYLOAD: if (rx_vld && last_pay) st_nx = C_FOOTER;
            C_FOOTER:  if (rx_vld && last_trl) st_nx = C_PAYLOAD;
            default:   st_nx = C_PAYLOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_PAYLOAD;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            wbank   <= '0;
            shreg   <= '0;
            go      <= 1'b0;
            go_trl  <= '0;
            go_bank <= '0;
        end else begin
            go <= 1'b0;
            if (rx_vld) begin
                if (st == C_FOOTER) begin
                    shreg <= {shreg[15:0], rx_byte};
                end
                if (last_trl) begin
                    cnt     <= '0;
                    go      <= 1'b1;
                    go_trl  <= trailer_t'({shreg, rx_byte});
                    go_bank <= wbank;
                    wbank   <= (wbank == BW'(BANKS - 1)) ? '0 : wbank + 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [7:0] mem [PAY];
        always_ff @(posedge clk) begin
            if (rx_vld && st == C_PAYLOAD && wbank == BW'(b)) begin
                mem[cnt[PW-1:0]] <= rx_byte;
            end
        end
        assign rd_lane[b] = mem[rd_pos];
    end

    assign rd_byte = rd_lane[rd_bank];

    // R1: counter never leaves the chunk range
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(CHUNK));
    // R1: trailer phase only in upper part of the chunk
    p_trl_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_FOOTER) |-> (cnt >= CW'(PAY)));

endmodule

// File: rtl/rdf_status.sv
module rdf_status
    import rdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  trailer_t   go_trl,
    output logic [4:0] st_rca,
    output logic [4:0] st_txc,
    output logic       st_exst,
    output logic       st_hdrb,
    output logic       st_sync
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_rca  <= '0;
            st_txc  <= '0;
            st_exst <= 1'b0;
            st_hdrb <= 1'b0;
            st_sync <= 1'b0;
        end else if (go && trailer_good(go_trl)) begin
            st_rca  <= go_trl.rca;
            st_txc  <= go_trl.txc;
            st_exst <= go_trl.exst;
            st_hdrb <= go_trl.hdrb;
            st_sync <= go_trl.sync;
        end
    end

    // R2: a bad trailer leaves status untouched
    p_hold_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !(^go_trl)) |=> ($stable(st_rca) && $stable(st_txc)));
    // R10: status moves only when a trailer is posted
    p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(st_rca) && $stable(st_txc) && $stable(st_sync)));

endmodule

// File: rtl/rdf_emit.sv
module rdf_emit
    import rdf_pkg::*;
#(
    parameter int PAY   = 64,
    parameter int BANKS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  trailer_t                 go_trl,
    input  logic [$clog2(BANKS)-1:0] go_bank,
    output logic [$clog2(BANKS)-1:0] rd_bank,
    output logic [$clog2(PAY)-1:0]   rd_pos,
    input  logic [7:0]               rd_byte,
    output logic                     out_vld,
    output logic [7:0]               out_byte,
    output logic                     out_sof,
    output logic                     out_eof,
    output logic                     out_drop,
    output logic                     out_ts,
    output logic                     par_err,
    output logic                     proto_err
);
    localparam int PW = $clog2(PAY);
    localparam logic [PW-1:0] LAST = PW'(PAY - 1);

    em_st_t         st, st_nx;
    logic [PW-1:0]  pos, tail_last, head_first, head_last;
    logic           tail_eof, head_eof, head_pend, fd_q, ts_q, open_q;

    // Trailer decode
    logic           good;
    logic [PW-1:0]  strt, ebo;
    logic           d_tail, d_tail_eof, d_head, d_head_eof, d_open, d_proto;
    logic [PW-1:0]  d_tail_last, d_head_first, d_head_last;

    always_comb begin
        good         = trailer_good(go_trl);
        strt         = PW'({go_trl.swo, 2'b00});
        ebo          = PW'(go_trl.ebo);
        d_tail       = 1'b0;
        d_tail_eof   = 1'b0;
        d_tail_last  = LAST;
        d_head       = 1'b0;
        d_head_eof   = 1'b0;
        d_head_first = '0;
        d_head_last  = LAST;
        d_open       = open_q;
        d_proto      = 1'b0;
        if (good && go_trl.dv) begin
            if (go_trl.sv && go_trl.ev && ebo >= strt) begin
                d_head       = 1'b1;
                d_head_first = strt;
                d_head_last  = ebo;
                d_head_eof   = 1'b1;
                d_open       = 1'b0;
            end else begin
                if (go_trl.ev) begin
                    if (open_q) begin
                        d_tail      = 1'b1;
                        d_tail_last = ebo;
                        d_tail_eof  = 1'b1;
                    end else begin
                        d_proto = 1'b1;
                    end
                    d_open = 1'b0;
                end else if (!go_trl.sv && open_q) begin
                    d_tail = 1'b1;
                end
                if (go_trl.sv) begin
                    d_head       = 1'b1;
                    d_head_first = strt;
                    d_open       = 1'b1;
                end
            end
        end
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            EM_IDLE: if (go) st_nx = d_tail ? EM_TAIL : (d_head ? EM_HEAD : EM_IDLE);
            EM_TAIL: if (pos == tail_last) st_nx = head_pend ? EM_HEAD : EM_IDLE;
            EM_HEAD: if (pos == head_last) st_nx = EM_IDLE;
            default: st_nx = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= EM_IDLE;
        else        st <= st_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos        <= '0;
            tail_last  <= '0;
            tail_eof   <= 1'b0;
            head_first <= '0;
            head_last  <= '0;
            head_eof   <= 1'b0;
            head_pend  <= 1'b0;
            fd_q       <= 1'b0;
            ts_q       <= 1'b0;
            open_q     <= 1'b0;
            rd_bank    <= '0;
            par_err    <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            par_err   <= go && !good;
            proto_err <= go && d_proto;
            unique case (st)
                EM_IDLE: if (go) begin
                    tail_last  <= d_tail_last;
                    tail_eof   <= d_tail_eof;
                    head_first <= d_head_first;
                    head_last  <= d_head_last;
                    head_eof   <= d_head_eof;
                    head_pend  <= d_head;
                    fd_q       <= go_trl.fd;
                    ts_q       <= go_trl.rtsa;
                    open_q     <= d_open;
                    rd_bank    <= go_bank;
                    pos        <= d_tail ? '0 : d_head_first;
                end
                EM_TAIL: pos <= (pos == tail_last) ? head_first : pos + 1'b1;
                EM_HEAD: pos <= pos + 1'b1;
                default: pos <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_pos   = pos;
        out_vld  = (st != EM_IDLE);
        out_byte = rd_byte;
        out_sof  = (st == EM_HEAD) && (pos == head_first);
        out_eof  = ((st == EM_TAIL) && (pos == tail_last) && tail_eof) ||
                   ((st == EM_HEAD) && (pos == head_last) && head_eof);
        out_drop = out_eof && fd_q;
        out_ts   = out_sof && ts_q;
    end

    // R11: replay of one chunk is finished before the next trailer posts
    p_go_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st == EM_IDLE));
    // R5: drop flag only on an end-of-frame byte
    p_drop_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_drop |-> (out_eof && out_vld));
    // R2: a rejected trailer produces no output in the following cycle
    p_perr_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> !out_vld);
    // R2: error pulses last one cycle
    p_perr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> !par_err);
    // R4: start flag only with valid output
    p_sof_vld_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_vld);

endmodule

// File: rtl/rxchunk_deframer.sv
module rxchunk_deframer
    import rdf_pkg::*;
#(
    parameter int PAY   = 64,
    parameter int BANKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_vld,
    input  logic [7:0] rx_byte,
    output logic       out_vld,
    output logic [7:0] out_byte,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_drop,
    output logic       out_ts,
    output logic       par_err,
    output logic       proto_err,
    output logic [4:0] st_rca,
    output logic [4:0] st_txc,
    output logic       st_exst,
    output logic       st_hdrb,
    output logic       st_sync
);
    localparam int TRL = $bits(trailer_t) / 8;
    localparam int PW  = $clog2(PAY);
    localparam int BW  = $clog2(BANKS);

    logic           go;
    trailer_t       go_trl;
    logic [BW-1:0]  go_bank, rd_bank;
    logic [PW-1:0]  rd_pos;
    logic [7:0]     rd_byte;

    rdf_collect #(.PAY(PAY), .TRL(TRL), .BANKS(BANKS)) u_collect (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .rd_bank(rd_bank), .rd_pos(rd_pos), .rd_byte(rd_byte),
        .go(go), .go_trl(go_trl), .go_bank(go_bank)
    );

    rdf_status u_status (
        .clk(clk), .rst_n(rst_n), .go(go), .go_trl(go_trl),
        .st_rca(st_rca), .st_txc(st_txc), .st_exst(st_exst),
        .st_hdrb(st_hdrb), .st_sync(st_sync)
    );

    rdf_emit #(.PAY(PAY), .BANKS(BANKS)) u_emit (
        .clk(clk), .rst_n(rst_n), .go(go), .go_trl(go_trl), .go_bank(go_bank),
        .rd_bank(rd_bank), .rd_pos(rd_pos), .rd_byte(rd_byte),
        .out_vld(out_vld), .out_byte(out_byte), .out_sof(out_sof),
        .out_eof(out_eof), .out_drop(out_drop), .out_ts(out_ts),
        .par_err(par_err), .proto_err(proto_err)
    );

endmodule

// File: tb/rxchunk_deframer_bench.sv
`timescale 1ns/1ps
module rxchunk_deframer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       out_vld, out_sof, out_eof, out_drop, out_ts, par_err, proto_err;
    logic [7:0] out_byte;
    logic [4:0] st_rca, st_txc;
    logic       st_exst, st_hdrb, st_sync;

    always #4 clk = ~clk;

    rxchunk_deframer u_rxchunk_deframer (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .out_vld(out_vld), .out_byte(out_byte), .out_sof(out_sof),
        .out_eof(out_eof), .out_drop(out_drop), .out_ts(out_ts),
        .par_err(par_err), .proto_err(proto_err), .st_rca(st_rca),
        .st_txc(st_txc), .st_exst(st_exst), .st_hdrb(st_hdrb), .st_sync(st_sync)
    );

    int total = 0;
    int bad = 0;
    logic [11:0] expq[$];
    logic [7:0]  pl [64];
    bit          open_m = 1'b0;
    bit          p_exp, x_exp;
    logic [12:0] st_exp = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit exst, hdrb, sync, input logic [4:0] rca,
                                       input bit dv, sv, input logic [3:0] swo, input bit fd, ev,
                                       input logic [5:0] ebo, input bit rtsa, input logic [4:0] txc,
                                       input bit badp);
        logic [31:0] w;
        w = {exst, hdrb, sync, rca, 2'b00, dv, sv, swo, fd, ev, ebo, rtsa, 1'b0, txc, 1'b0};
        w[0] = ~(^w[31:1]) ^ badp;
        return w;
    endfunction

    task automatic push(input int from, input int to, input bit sof, input bit eof,
                        input bit drop, input bit ts);
        for (int i = from; i <= to; i++)
            expq.push_back({ts && sof && i == from, drop && eof && i == to,
                            eof && i == to, sof && i == from, pl[i]});
    endtask

    // Expected behaviour from the requirements
    task automatic model(input logic [31:0] w);
        int s, e;
        p_exp = 1'b0;
        x_exp = 1'b0;
        if (^w == 1'b0) begin p_exp = 1'b1; return; end          // R2
        st_exp = {w[28:24], w[5:1], w[31], w[30], w[29]};       // R10
        if (!w[21]) return;                                      // R3
        s = 4 * w[19:16];
        e = w[13:8];
        if (w[20] && w[14] && e >= s) begin                      // R9
            push(s, e, 1'b1, 1'b1, w[15], w[7]);
            open_m = 1'b0;
            return;
        end
        if (w[14]) begin                                         // R5, R6, R7
            if (open_m) push(0, e, 1'b0, 1'b1, w[15], 1'b0);
            else x_exp = 1'b1;
            open_m = 1'b0;
        end else if (!w[20] && open_m) begin                     // R8
            push(0, 63, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        if (w[20]) begin                                         // R4
            push(s, 63, 1'b1, 1'b0, 1'b0, w[7]);
            open_m = 1'b1;
        end
    endtask

    task automatic send(input logic [31:0] w, input bit gaps);
        for (int i = 0; i < 64; i++) pl[i] = 8'($urandom);
        model(w);
        for (int i = 0; i < 68; i++) begin
            if (gaps && ($urandom % 6 == 0)) begin
                @(negedge clk);
                rx_vld = 1'b0;
            end
            @(negedge clk);
            rx_vld  = 1'b1;
            rx_byte = (i < 64) ? pl[i] : w[8*(67-i) +: 8];
        end
        @(negedge clk);
        rx_vld = 1'b0;
        @(negedge clk);
        chk(par_err == p_exp, "R2 par_err", par_err, p_exp);
        chk(proto_err == x_exp, "R7 proto_err", proto_err, x_exp);
        chk({st_rca, st_txc, st_exst, st_hdrb, st_sync} == st_exp, "R10 status",
            {st_rca, st_txc, st_exst, st_hdrb, st_sync}, st_exp);
    endtask

    // Output stream monitor: R4 R5 R6 R8 R9 R11
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R11 unexpected byte", {out_ts, out_drop, out_eof, out_sof, out_byte}, 0);
            end else begin
                logic [11:0] e;
                e = expq.pop_front();
                chk({out_ts, out_drop, out_eof, out_sof, out_byte} == e, "R4 R5 R6 R8 R9 stream",
                    {out_ts, out_drop, out_eof, out_sof, out_byte}, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(!out_vld && st_rca == 0 && st_txc == 0 && !par_err, "R10 reset",
            {out_vld, st_rca, st_txc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 open, R8 continuation, R5 close with drop
        send(mk(0,0,1,5'd3, 1,1,4'd2, 0,0,6'd0, 0,5'd7, 0), 0);
        send(mk(0,0,1,5'd2, 1,0,4'd0, 0,0,6'd0, 0,5'd6, 0), 0);
        send(mk(1,0,1,5'd1, 1,0,4'd0, 1,1,6'd10, 0,5'd5, 0), 0);
        // R7 end without open frame
        send(mk(0,1,0,5'd0, 1,0,4'd0, 0,1,6'd20, 0,5'd4, 0), 0);
        // R8 no frame open: nothing
        send(mk(0,0,0,5'd0, 1,0,4'd0, 0,0,6'd0, 0,5'd4, 0), 0);
        // R4 start at last word, R6 end-then-start, R5 close at byte 63
        send(mk(0,0,1,5'd9, 1,1,4'd15, 0,0,6'd0, 1,5'd1, 0), 0);
        send(mk(0,0,1,5'd8, 1,1,4'd3, 0,1,6'd5, 1,5'd2, 0), 0);
        // R2 bad parity keeps frame open and status
        send(mk(1,1,0,5'd31, 1,0,4'd0, 0,1,6'd7, 0,5'd31, 1), 0);
        send(mk(0,0,1,5'd0, 1,0,4'd0, 0,1,6'd63, 0,5'd3, 0), 0);
        // R3 data valid clear
        send(mk(0,0,1,5'd4, 0,1,4'd0, 0,1,6'd63, 1,5'd9, 0), 0);
        // R9 full single frame, R9 abandon on restart
        send(mk(0,0,1,5'd0, 1,1,4'd0, 0,1,6'd63, 1,5'd9, 0), 0);
        send(mk(0,0,1,5'd0, 1,1,4'd1, 0,0,6'd0, 0,5'd9, 0), 0);
        send(mk(0,0,1,5'd0, 1,1,4'd4, 1,1,6'd16, 0,5'd9, 0), 0);
        // R11 back to back, then random with gaps
        for (int n = 0; n < 300; n++) begin
            bit sv, ev;
            sv = $urandom % 2;
            ev = $urandom % 2;
            send(mk($urandom % 2, $urandom % 2, $urandom % 2, 5'($urandom),
                    ($urandom % 8) != 0, sv, 4'($urandom), ev && ($urandom % 2), ev,
                    6'($urandom), sv && ($urandom % 2), 5'($urandom),
                    ($urandom % 10) == 0), n >= 100);
        end
        repeat (80) @(negedge clk);
        chk(expq.size() == 0, "R11 all bytes emitted", expq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule